// File: doc/BRIEF.md
# Audio Frame Sequencer with IRQ

This block is the low-rate timing source of a sound generator. It counts CPU clock cycles and, at fixed points in a repeating sequence, emits one-cycle quarter-frame and half-frame strobes. Those strobes step the envelope, linear-counter, length-counter and sweep units of the tone channels, which sit outside this block. With default parameters the steps land about 240 times per second.

Software picks one of two sequences by writing the mode register. Bit 7 selects the 4-step or the 5-step pattern. Bit 6 suppresses the frame interrupt. The 4-step pattern can raise a sticky frame interrupt flag on its last step. A status-register read strobe clears that flag.

A mode write does not restart the sequence at once. The restart waits for cycle parity and lands 2 or 3 cycles after the write. If the new mode is the 5-step pattern, the restart also emits one quarter-frame strobe and one half-frame strobe.

Top module: `frame_sequencer`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, both strobes are 0, `frameIrq` is 0 and `irqN` is 1. Reset leaves the block as a write of 0x00 would: 4-step mode, interrupt allowed, step counter at 0. In cycle n after reset the counter holds n, until the first wrap or restart.
- R2: In 4-step mode (mode bit 7 = 0), `quarterPulse` is 1 in the cycles where the counter equals STEP1, STEP2, STEP3 or STEP4. `halfPulse` is 1 only at STEP2 and STEP4. The counter returns to 0 in the cycle after STEP4.
- R3: In 5-step mode (bit 7 = 1), `quarterPulse` fires at STEP1, STEP2, STEP3 and STEP5, but not at STEP4. `halfPulse` fires at STEP2 and STEP5. The counter returns to 0 after STEP5. The frame interrupt flag is never set in this mode.
- R4: In 4-step mode with the inhibit bit clear, the counter reaching STEP4 sets the flag. `frameIrq` is 1 and `irqN` is 0 from the next cycle. The flag stays set until something clears it.
- R5: A mode write with bit 6 = 1 clears the flag, so `frameIrq` is 0 from the next cycle. While bit 6 stays set, STEP4 does not set the flag.
- R6: A cycle with `statusRd` high clears the flag from the next cycle on.
- R7: In the cycle where the flag is being set, `statusIrqBit` reads 1. A `statusRd` in that same cycle does not clear the flag.
- R8: Cycle parity counts from reset, and cycle 0 is even. A mode write in an even cycle W makes the restart take effect in cycle W+3. A write in an odd cycle makes it take effect in W+2. In cycle restart+1 the counter is 0, so the first step strobe comes STEP1+1 cycles after the restart cycle. The old sequence fires no further steps after the restart.
- R9: In the restart cycle, a written bit 7 of 1 drives both `quarterPulse` and `halfPulse` high. A written bit 7 of 0 drives neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWrEn | input | 1 | Mode register write strobe, one cycle |
| modeWrData | input | 8 | Write data: bit 7 = 5-step mode, bit 6 = IRQ inhibit |
| statusRd | input | 1 | Status register read strobe |
| quarterPulse | output | 1 | Quarter-frame strobe |
| halfPulse | output | 1 | Half-frame strobe |
| frameIrq | output | 1 | Frame interrupt flag |
| irqN | output | 1 | Active-low interrupt line driven by the flag |
| statusIrqBit | output | 1 | Flag value a status read returns this cycle |

## Verification
The bench uses short step points. One vector table walks a 4-step sequence from reset, including the wrap and the sticky flag. Samples at event cycles and at cycles beside them separate the right step placement from an off-by-one counter. Mode writes are issued in an even cycle and in an odd cycle, so a delay fixed at 2 or at 3 fails one of the two cases. Checks at the old sequence's next step point show whether the restart really happened. The flag is tested with a plain read, a read in the cycle the flag is set, and an inhibit write followed by a full 4-step sequence.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  // Strobes the control sends to the step datapath each cycle
  typedef struct packed {
    logic restart;   // sequence restart takes effect this cycle
    logic fiveStep;  // current mode is the 5-step pattern
  } fseqStrobes_t;
endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeWrEn,
  input  logic [7:0]   modeWrData,
  input  logic         statusRd,
  input  logic         irqStep,
  output fseqStrobes_t strobes,
  output logic         irqFlag,
  output logic         irqReadBit
);
  localparam int MODE_BIT = 7;
  localparam int INH_BIT  = 6;

  logic       modeFive;
  logic       inhibit;
  logic       oddCycle;
  logic [1:0] restartDly;
  logic       setIrq;
  logic       inhWrite;

  assign setIrq   = irqStep && !inhibit;
  assign inhWrite = modeWrEn && modeWrData[INH_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeFive   <= 1'b0;
      inhibit    <= 1'b0;
      oddCycle   <= 1'b0;
      restartDly <= 2'd0;
      irqFlag    <= 1'b0;
    end else begin
      oddCycle <= !oddCycle;
      if (modeWrEn) begin
        modeFive   <= modeWrData[MODE_BIT];
        inhibit    <= modeWrData[INH_BIT];
        // odd-cycle write: restart 2 cycles later, even-cycle write: 3
        restartDly <= oddCycle ? 2'd2 : 2'd3;
      end else if (restartDly != 2'd0) begin
        restartDly <= restartDly - 2'd1;
      end
      if (inhWrite)      irqFlag <= 1'b0;
      else if (setIrq)   irqFlag <= 1'b1;
      else if (statusRd) irqFlag <= 1'b0;
    end
  end

  assign strobes.restart  = (restartDly == 2'd1);
  assign strobes.fiveStep = modeFive;
  assign irqReadBit       = irqFlag || setIrq;
endmodule

// File: rtl/fseq_datapath.sv
module fseq_datapath
  import fseq_pkg::*;
#(
  parameter int STEP1 = 7457,
  parameter int STEP2 = 14913,
  parameter int STEP3 = 22371,
  parameter int STEP4 = 29829,
  parameter int STEP5 = 37281
) (
  input  logic         clk,
  input  logic         rstN,
  input  fseqStrobes_t strobes,
  output logic         quarterPulse,
  output logic         halfPulse,
  output logic         irqStep
);
  localparam int NUM_STEPS = 5;
  localparam int CNT_W     = $clog2(STEP5 + 1);
  localparam int STEP_AT [NUM_STEPS] = '{STEP1, STEP2, STEP3, STEP4, STEP5};

  logic [CNT_W-1:0]     cycleCnt;
  logic [NUM_STEPS-1:0] hit;
  logic                 lastHit;

  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_cmp
    assign hit[i] = (cycleCnt == CNT_W'(STEP_AT[i]));
  end

  assign lastHit = strobes.fiveStep ? hit[4] : hit[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          cycleCnt <= '0;
    else if (strobes.restart || lastHit) cycleCnt <= '0;
    else                                cycleCnt <= cycleCnt + 1'b1;
  end

  always_comb begin
    if (strobes.restart) begin
      quarterPulse = strobes.fiveStep;
      halfPulse    = strobes.fiveStep;
      irqStep      = 1'b0;
    end else begin
      quarterPulse = hit[0] | hit[1] | hit[2] | lastHit;
      halfPulse    = hit[1] | lastHit;
      irqStep      = !strobes.fiveStep && hit[3];
    end
  end
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import fseq_pkg::*;
#(
  parameter int STEP1 = 7457,
  parameter int STEP2 = 14913,
  parameter int STEP3 = 22371,
  parameter int STEP4 = 29829,
  parameter int STEP5 = 37281
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWrEn,
  input  logic [7:0] modeWrData,
  input  logic       statusRd,
  output logic       quarterPulse,
  output logic       halfPulse,
  output logic       frameIrq,
  output logic       irqN,
  output logic       statusIrqBit
);
  fseqStrobes_t strobes;
  logic         irqStep;
  logic         restartNow;
  logic         fiveNow;

  fseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .statusRd(statusRd), .irqStep(irqStep), .strobes(strobes),
    .irqFlag(frameIrq), .irqReadBit(statusIrqBit)
  );

  fseq_datapath #(
    .STEP1(STEP1), .STEP2(STEP2), .STEP3(STEP3), .STEP4(STEP4), .STEP5(STEP5)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .quarterPulse(quarterPulse), .halfPulse(halfPulse), .irqStep(irqStep)
  );

  assign irqN       = !frameIrq;
  assign restartNow = strobes.restart;
  assign fiveNow    = strobes.fiveStep;
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       modeWrEn,
  input logic [7:0] modeWrData,
  input logic       statusRd,
  input logic       quarterPulse,
  input logic       halfPulse,
  input logic       frameIrq,
  input logic       statusIrqBit,
  input logic       restartNow,
  input logic       fiveNow
);
  // R2 / R3: every half-frame strobe coincides with a quarter-frame strobe
  a_r2_half_with_quarter: assert property (@(posedge clk) disable iff (!rstN)
    halfPulse |-> quarterPulse);

  // R3: no flag set is in progress while in 5-step mode
  a_r3_five_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    fiveNow |-> !(statusIrqBit && !frameIrq));

  // R5: a write with inhibit set clears the flag
  a_r5_inhibit_clears: assert property (@(posedge clk) disable iff (!rstN)
    (modeWrEn && modeWrData[6]) |=> !frameIrq);

  // R6: a read with no set in progress clears the flag
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !modeWrEn && !(statusIrqBit && !frameIrq)) |=> !frameIrq);

  // R7: a set in progress survives a coincident read
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (statusIrqBit && !frameIrq && !(modeWrEn && modeWrData[6])) |=> frameIrq);

  // R9: restart into 5-step mode emits both strobes
  a_r9_restart_pulses: assert property (@(posedge clk) disable iff (!rstN)
    (restartNow && fiveNow) |-> (quarterPulse && halfPulse));
endmodule

bind frame_sequencer fseq_checker u_chk (
  .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
  .statusRd(statusRd), .quarterPulse(quarterPulse), .halfPulse(halfPulse),
  .frameIrq(frameIrq), .statusIrqBit(statusIrqBit),
  .restartNow(restartNow), .fiveNow(fiveNow)
);

// File: tb/frame_sequencer_tb.sv
module frame_sequencer_tb;
  localparam int S1 = 10, S2 = 21, S3 = 33, S4 = 44, S5 = 56;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeWrEn = 1'b0;
  logic [7:0] modeWrData = 8'h00;
  logic       statusRd = 1'b0;
  logic       quarterPulse, halfPulse, frameIrq, irqN, statusIrqBit;
  int         cyc = 0;
  int         nChecks = 0;
  int         nFails = 0;

  always #2.5 clk = !clk;

  always @(posedge clk) begin
    if (rstN) cyc <= cyc + 1;
  end

  frame_sequencer #(.STEP1(S1), .STEP2(S2), .STEP3(S3), .STEP4(S4), .STEP5(S5)) u_dut (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .statusRd(statusRd), .quarterPulse(quarterPulse), .halfPulse(halfPulse),
    .frameIrq(frameIrq), .irqN(irqN), .statusIrqBit(statusIrqBit)
  );

  typedef struct packed {
    logic [15:0] at;
    logic        q;
    logic        h;
    logic        irq;
  } vec_t;

  // 4-step sequence from reset: sample cycle, quarter, half, flag
  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{16'd0,  1'b0, 1'b0, 1'b0},
    '{16'd9,  1'b0, 1'b0, 1'b0},
    '{16'd10, 1'b1, 1'b0, 1'b0},
    '{16'd11, 1'b0, 1'b0, 1'b0},
    '{16'd21, 1'b1, 1'b1, 1'b0},
    '{16'd33, 1'b1, 1'b0, 1'b0},
    '{16'd44, 1'b1, 1'b1, 1'b0},
    '{16'd45, 1'b0, 1'b0, 1'b1},
    '{16'd55, 1'b1, 1'b0, 1'b1},
    '{16'd66, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic waitTo(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic writeMode(input logic [7:0] d);
    modeWrEn = 1'b1;
    modeWrData = d;
    @(negedge clk);
    modeWrEn = 1'b0;
  endtask

  initial begin
    #100000;
    nFails++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("%0d/%0d checks passed", nChecks - nFails + 1, nChecks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 quarter in reset", quarterPulse, 0);
    chk("R1 half in reset", halfPulse, 0);
    chk("R1 flag in reset", frameIrq, 0);
    chk("R1 irqN in reset", irqN, 1);
    rstN = 1'b1;

    // R2 and R4 from the vector table
    for (int i = 0; i < NVEC; i++) begin
      waitTo(int'(VECS[i].at));
      chk("R2 table quarter", quarterPulse, VECS[i].q);
      chk("R2 table half", halfPulse, VECS[i].h);
      chk("R4 table flag", frameIrq, VECS[i].irq);
      chk("R4 table irqN", irqN, !VECS[i].irq);
    end

    // R6: read clears
    waitTo(67);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
    chk("R6 flag after read", frameIrq, 0);
    chk("R6 irqN after read", irqN, 1);

    // R8 even-cycle write (68) -> restart at 71; R9 pulses for 5-step
    writeMode(8'h80);
    waitTo(70);
    chk("R8 no early restart pulse", quarterPulse, 0);
    waitTo(71);
    chk("R9 restart quarter", quarterPulse, 1);
    chk("R9 restart half", halfPulse, 1);
    waitTo(81);
    chk("R8 step1 not one early", quarterPulse, 0);
    waitTo(82);
    chk("R8 step1 after restart", quarterPulse, 1);
    waitTo(93);
    chk("R3 step2 quarter", quarterPulse, 1);
    chk("R3 step2 half", halfPulse, 1);
    waitTo(116);
    chk("R3 step4 skipped quarter", quarterPulse, 0);
    chk("R3 step4 skipped half", halfPulse, 0);
    waitTo(128);
    chk("R3 step5 quarter", quarterPulse, 1);
    chk("R3 step5 half", halfPulse, 1);
    waitTo(129);
    chk("R3 no flag in 5-step", frameIrq, 0);

    // R8 odd-cycle write (141) -> restart at 143; R9 no pulses for 4-step
    waitTo(141);
    writeMode(8'h00);
    waitTo(143);
    chk("R9 mode0 restart no quarter", quarterPulse, 0);
    chk("R9 mode0 restart no half", halfPulse, 0);
    waitTo(150);
    chk("R8 old step2 suppressed", quarterPulse, 0);
    waitTo(153);
    chk("R8 odd step1 not early", quarterPulse, 0);
    waitTo(154);
    chk("R8 odd step1", quarterPulse, 1);

    // R7: read in the set cycle (188)
    waitTo(187);
    chk("R7 flag clear before set", frameIrq, 0);
    waitTo(188);
    statusRd = 1'b1;
    #1;
    chk("R7 status bit reads 1", statusIrqBit, 1);
    @(negedge clk);
    statusRd = 1'b0;
    chk("R7 flag survives read", frameIrq, 1);

    // R5: inhibit write at 190 clears, restart at 193, step4 at 238
    waitTo(190);
    writeMode(8'h40);
    chk("R5 inhibit clears flag", frameIrq, 0);
    chk("R5 irqN high", irqN, 1);
    waitTo(238);
    chk("R5 step4 still steps", quarterPulse, 1);
    chk("R5 no set in progress", statusIrqBit, 0);
    waitTo(239);
    chk("R5 flag stays clear", frameIrq, 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule